// File: doc/BRIEF.md
# Serial-Load Interleaved-Read Test Pattern Memory

This block is an on-chip store of test codes for a high-speed converter core. A slow serial port fills it one bit per clock, so the fast core never needs a fast off-chip data stream. Once it is filled and enabled, it plays the stored codes back as one 6-bit word per clock and repeats them without a break.

The storage is a bank of 48 circulating shift registers of 104 bits each, 4992 bits in all. During loading they form a single serial chain. During playback they form 8 interleave phases of 6 registers, one register for each bit of the output code. A phase counter picks the group whose register heads form the next word. That group then rotates by one position, so that on every playback clock exactly six registers shift, whatever the data. The supply disturbance is therefore the same for every stored pattern.

Top module: `tpm_pattern_mem`

## Requirements
- R1: After reset the block is in load mode, `load_done_o` is 0 and `word_o` is the mid-scale code 6'b100000 (32).
- R2: In load mode, each clock with `ser_valid_i` high takes `ser_data_i` as the next serial bit. `load_done_o` is 0 after 4991 accepted bits and 1 after exactly 4992.
- R3: Serial bits offered after `load_done_o` is 1 are ignored and leave the stored pattern unchanged.
- R4: Playback starts only when `run_en_i` is high and the load is complete. While the load is incomplete, `run_en_i` has no effect, `word_o` stays 32 and the store does not move.
- R5: Take serial bit number q (counted from 0). With r = q / 104 and j = q mod 104, it becomes bit r mod 6 of playback word 8*j + r / 6. Word 0 appears on the second clock after `run_en_i` first goes high with the load complete, and one further word appears on each later playback clock.
- R6: Playback repeats with a period of 832 words, so word 832 equals word 0.
- R7: While playing, a low `run_en_i` makes `word_o` equal 32 from the next clock and pauses the sequence. When `run_en_i` is high again, playback resumes with the word that follows the last one shown.
- R8: A high `restart_i` returns the block to load mode. From the next clock `load_done_o` is 0 and `word_o` is 32, and a fresh load of 4992 bits is needed.
- R9: On every playback clock exactly one phase group of registers rotates, and no register rotates when not playing.
- R10: On each playback clock the phase counter advances by one, wrapping from 7 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for loading and playback |
| rst_ni | input | 1 | Active-low asynchronous reset |
| restart_i | input | 1 | Return to load mode and clear the load count |
| ser_valid_i | input | 1 | Serial bit strobe in load mode |
| ser_data_i | input | 1 | Serial data bit |
| run_en_i | input | 1 | Playback enable; low holds the output at mid-scale |
| load_done_o | output | 1 | High once all 4992 bits are loaded |
| word_o | output | 6 | Registered output code |

## Verification
On every clock the assertions check the following: the mid-scale output whenever the block did not play, that restart clears the done flag, that the done flag holds until restart, that exactly one group rotates per playback clock, and the phase step. The serial-to-word bit mapping, the exact count of 4992 loaded bits, the discarding of surplus bits, pause and resume continuity, and the 832-word loop can only be shown by the bench. It loads two computed patterns and compares every played word with the value worked out from the mapping.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  typedef enum logic {
    MODE_LOAD = 1'b0,
    MODE_RUN  = 1'b1
  } tpm_mode_e;
endpackage

// File: rtl/tpm_lane.sv
// One circulating shift register; head is bit 0.
module tpm_lane #(
  parameter int DEPTH = 104
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_shift_i,
  input  logic rot_en_i,
  input  logic ser_i,
  output logic head_o
);
  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (load_shift_i) begin
      sr_q <= {ser_i, sr_q[DEPTH-1:1]};
    end else if (rot_en_i) begin
      sr_q <= {sr_q[0], sr_q[DEPTH-1:1]};
    end
  end

  assign head_o = sr_q[0];
endmodule

// File: rtl/tpm_ctrl.sv
module tpm_ctrl
  import tpm_pkg::*;
#(
  parameter int TOTAL_BITS = 4992,
  parameter int PHASES     = 8,
  localparam int CW        = $clog2(TOTAL_BITS + 1),
  localparam int PW        = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              ser_valid_i,
  input  logic              run_en_i,
  output logic              load_shift_o,
  output logic              play_o,
  output logic              load_done_o,
  output logic [PW-1:0]     phase_o,
  output logic [PHASES-1:0] grp_rot_o
);
  localparam logic [CW-1:0] CNT_FULL   = CW'(TOTAL_BITS);
  localparam logic [PW-1:0] PHASE_LAST = PW'(PHASES - 1);

  tpm_mode_e       mode_q;
  logic [CW-1:0]   cnt_q;
  logic [PW-1:0]   phase_q;

  assign load_done_o  = (cnt_q == CNT_FULL);
  assign load_shift_o = (mode_q == MODE_LOAD) && ser_valid_i && !load_done_o && !restart_i;
  assign play_o       = (mode_q == MODE_RUN) && run_en_i && !restart_i;
  assign phase_o      = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_LOAD;
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (restart_i) begin
      mode_q  <= MODE_LOAD;
      cnt_q   <= '0;
      phase_q <= '0;
    end else begin
      if (load_shift_o) cnt_q <= cnt_q + 1'b1;
      if (mode_q == MODE_LOAD && load_done_o && run_en_i) mode_q <= MODE_RUN;
      if (play_o) phase_q <= (phase_q == PHASE_LAST) ? '0 : phase_q + 1'b1;
    end
  end

  // One group rotates per playback cycle: constant switching activity.
  for (genvar p = 0; p < PHASES; p++) begin : g_rot
    assign grp_rot_o[p] = play_o && (phase_q == PW'(p));
  end
endmodule

// File: rtl/tpm_readout.sv
module tpm_readout #(
  parameter int LANES  = 6,
  parameter int PHASES = 8,
  localparam int NREG  = LANES * PHASES,
  localparam int PW    = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             play_i,
  input  logic [PW-1:0]    phase_i,
  input  logic [NREG-1:0]  heads_i,
  output logic [LANES-1:0] word_o
);
  localparam logic [LANES-1:0] MID = LANES'(1) << (LANES - 1);

  logic [LANES-1:0] grp_word [PHASES];
  logic [LANES-1:0] sel_word;

  for (genvar p = 0; p < PHASES; p++) begin : g_grp
    assign grp_word[p] = heads_i[p*LANES +: LANES];
  end

  always_comb begin
    sel_word = MID;
    for (int p = 0; p < PHASES; p++) begin
      if (phase_i == PW'(p)) sel_word = grp_word[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_o <= MID;
    else if (play_i) word_o <= sel_word;
    else             word_o <= MID;
  end
endmodule

// File: rtl/tpm_pattern_mem.sv
module tpm_pattern_mem #(
  parameter int LANES  = 6,
  parameter int PHASES = 8,
  parameter int DEPTH  = 104,
  localparam int NREG  = LANES * PHASES,
  localparam int TOTAL = NREG * DEPTH,
  localparam int PW    = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             ser_valid_i,
  input  logic             ser_data_i,
  input  logic             run_en_i,
  output logic             load_done_o,
  output logic [LANES-1:0] word_o
);
  logic              load_shift;
  logic              play;
  logic [PW-1:0]     phase;
  logic [PHASES-1:0] grp_rot;
  logic [NREG-1:0]   heads;

  tpm_ctrl #(
    .TOTAL_BITS(TOTAL),
    .PHASES    (PHASES)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart_i),
    .ser_valid_i (ser_valid_i),
    .run_en_i    (run_en_i),
    .load_shift_o(load_shift),
    .play_o      (play),
    .load_done_o (load_done_o),
    .phase_o     (phase),
    .grp_rot_o   (grp_rot)
  );

  // Load chain: serial in enters the last register, register 0 head is the chain end.
  for (genvar r = 0; r < NREG; r++) begin : g_lane
    logic chain_in;
    if (r == NREG - 1) begin : g_tail
      assign chain_in = ser_data_i;
    end else begin : g_mid
      assign chain_in = heads[r+1];
    end
    tpm_lane #(.DEPTH(DEPTH)) u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_shift_i(load_shift),
      .rot_en_i    (grp_rot[r / LANES]),
      .ser_i       (chain_in),
      .head_o      (heads[r])
    );
  end

  tpm_readout #(
    .LANES (LANES),
    .PHASES(PHASES)
  ) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .play_i (play),
    .phase_i(phase),
    .heads_i(heads),
    .word_o (word_o)
  );
endmodule

// File: rtl/tpm_checks.sv
module tpm_checks #(
  parameter int LANES  = 6,
  parameter int PHASES = 8,
  localparam int PW    = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              restart_i,
  input logic              load_done_o,
  input logic [LANES-1:0]  word_o,
  input logic              play_i,
  input logic [PW-1:0]     phase_i,
  input logic [PHASES-1:0] grp_rot_i
);
  localparam logic [LANES-1:0] MID = LANES'(1) << (LANES - 1);

  a_r7_idle_midscale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !play_i |=> word_o == MID);

  a_r8_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!load_done_o && word_o == MID));

  a_r2_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_done_o && !restart_i) |=> load_done_o);

  a_r9_one_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    play_i |-> $countones(grp_rot_i) == 1);

  a_r9_no_rot_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !play_i |-> grp_rot_i == '0);

  a_r10_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (play_i && phase_i != PW'(PHASES - 1)) |=> phase_i == $past(phase_i) + 1'b1);

  a_r10_phase_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (play_i && phase_i == PW'(PHASES - 1)) |=> phase_i == '0);
endmodule

bind tpm_pattern_mem tpm_checks #(.LANES(LANES), .PHASES(PHASES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .restart_i  (restart_i),
  .load_done_o(load_done_o),
  .word_o     (word_o),
  .play_i     (play),
  .phase_i    (phase),
  .grp_rot_i  (grp_rot)
);

// File: tb/tpm_pattern_mem_test.sv
`timescale 1ns/1ps
module tpm_pattern_mem_test;
  localparam int LANES  = 6;
  localparam int PHASES = 8;
  localparam int DEPTH  = 104;
  localparam int NREG   = LANES * PHASES;
  localparam int TOTAL  = NREG * DEPTH;
  localparam int NWORDS = PHASES * DEPTH;
  localparam int MID    = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic restart_i = 1'b0;
  logic ser_valid_i = 1'b0;
  logic ser_data_i = 1'b0;
  logic run_en_i = 1'b0;
  logic load_done_o;
  logic [LANES-1:0] word_o;

  int n_tests = 0;
  int n_fail = 0;
  int pat [NWORDS];
  int pos;

  always #10 clk = ~clk;

  tpm_pattern_mem uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .restart_i  (restart_i),
    .ser_valid_i(ser_valid_i),
    .ser_data_i (ser_data_i),
    .run_en_i   (run_en_i),
    .load_done_o(load_done_o),
    .word_o     (word_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic make_pattern(input int seed);
    for (int k = 0; k < NWORDS; k++) pat[k] = (k * seed + (k >> 3) * 7 + seed) & 63;
  endtask

  // Serial bit q -> bit (r%LANES) of word PHASES*j + r/LANES (R5 mapping).
  function automatic logic ser_bit(input int q);
    int r, j;
    r = q / DEPTH;
    j = q % DEPTH;
    return 1'((pat[PHASES * j + r / LANES] >> (r % LANES)) & 1);
  endfunction

  // Drive bits lo..hi at negedges; leaves ser_valid_i high after the last.
  task automatic send_bits(input int lo, input int hi);
    for (int q = lo; q <= hi; q++) begin
      @(negedge clk);
      if (q == TOTAL - 1) check(load_done_o == 1'b0, "R2 done before last bit", load_done_o, 0);
      ser_valid_i = 1'b1;
      ser_data_i  = ser_bit(q);
    end
  endtask

  task automatic finish_load();
    @(negedge clk);
    check(load_done_o == 1'b1, "R2 done after 4992 bits", load_done_o, 1);
    ser_valid_i = 1'b0;
  endtask

  // Called at a negedge with run_en_i already high in run mode.
  task automatic play_words(input int n, input string req);
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      check(int'(word_o) == pat[pos % NWORDS], req, word_o, pat[pos % NWORDS]);
      pos++;
    end
  endtask

  task automatic start_play();
    @(negedge clk);
    run_en_i = 1'b1;
    @(negedge clk);
    check(int'(word_o) == MID, "R5 entry cycle midscale", word_o, MID);
  endtask

  initial begin
    #(20.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(load_done_o == 1'b0, "R1 done low in reset", load_done_o, 0);
    check(int'(word_o) == MID, "R1 midscale in reset", word_o, MID);
    rst_ni = 1'b1;
    @(negedge clk);
    check(int'(word_o) == MID, "R1 midscale after reset", word_o, MID);

    // Pattern A
    make_pattern(5);
    send_bits(0, 99);
    @(negedge clk);
    ser_valid_i = 1'b0;
    run_en_i = 1'b1;  // R4: no effect while load incomplete
    repeat (4) begin
      @(negedge clk);
      check(int'(word_o) == MID, "R4 run before load done", word_o, MID);
      check(load_done_o == 1'b0, "R4 still loading", load_done_o, 0);
    end
    run_en_i = 1'b0;
    send_bits(100, TOTAL - 1);
    finish_load();

    // R3 surplus bits ignored
    for (int q = 0; q < 40; q++) begin
      @(negedge clk);
      ser_valid_i = 1'b1;
      ser_data_i  = ~ser_bit(q);
    end
    @(negedge clk);
    ser_valid_i = 1'b0;
    check(load_done_o == 1'b1, "R3 done holds", load_done_o, 1);

    pos = 0;
    start_play();
    play_words(NWORDS, "R3 R5 word order");
    play_words(NWORDS, "R6 loop repeat");
    play_words(37, "R6 second wrap");

    // R7 pause and resume
    run_en_i = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check(int'(word_o) == MID, "R7 paused midscale", word_o, MID);
    end
    run_en_i = 1'b1;
    play_words(20, "R7 resume continuity");

    // R8 restart
    run_en_i = 1'b0;
    restart_i = 1'b1;
    @(negedge clk);
    restart_i = 1'b0;
    check(load_done_o == 1'b0, "R8 done cleared", load_done_o, 0);
    check(int'(word_o) == MID, "R8 midscale", word_o, MID);
    run_en_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(int'(word_o) == MID, "R8 R4 no play after restart", word_o, MID);
    end
    run_en_i = 1'b0;

    // Pattern B
    make_pattern(11);
    send_bits(0, TOTAL - 1);
    finish_load();
    pos = 0;
    start_play();
    play_words(NWORDS + 9, "R5 R6 pattern B");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule